// File: doc/BRIEF.md
# Windowed Watchdog Timer Core

This block is a watchdog counter for a chip that must catch a stuck processor. It runs from the fast system clock. It advances only on a one-cycle tick enable, and each tick stands for one period of a 1024 Hz oscillator. Software enables it, must send a restart strobe often enough, and gets a reset request if it does not. In window mode a restart is also illegal when it comes too soon. Each period therefore starts with a closed interval, in which a restart is fatal, and then an open interval, in which a restart is accepted.

One 8-bit setup word holds two exponential period codes. The upper nibble gives the closed-interval length and the lower nibble gives the time-out, which is also the open-interval length. The setup word takes its value from a nonvolatile boot value while reset is held. Software can rewrite it through a valid/ready write port, but only while the watchdog is idle. The write port never applies back-pressure: `cfg_wr_ready` is always high. A beat presented while the watchdog is enabled, running or fired is accepted and discarded. The reset request is a flop output and stays high until the next system reset.

Top module: `winwdog_top`

## Requirements
- R1: While `rst_n` is low, the setup word `cfg_q` loads `cfg_boot`, and `rst_req` is 0 once reset is released. Bits 7:4 of the word are the closed-interval code and bits 3:0 are the time-out code.
- R2: A code n with n <= MAX_CODE selects 2^(BASE_LOG2+n) ticks. With the defaults (BASE_LOG2=3, MAX_CODE=11) this is 8·2^n ticks, from 8 to 16384.
- R3: In normal mode (`win_mode`=0 when enabled), the clock edge on which `en` is first seen high starts the period, and any tick on that edge is not counted. `rst_req` rises on the clock edge of the L-th tick after that, where L is the time-out length.
- R4: In window mode with no restart, the closed interval of length W runs first, then the open interval of length P, and `rst_req` rises on the edge of the (W+P)-th tick.
- R5: A `clr` strobe seen during the closed interval sets `rst_req` on that same clock edge.
- R6: A `clr` strobe seen during the open interval reloads the counter and starts a new full period, beginning with a closed interval in window mode. If the strobe arrives together with the final tick, the restart takes priority.
- R7: A time-out code above MAX_CODE selects the longest legal length, 2^(BASE_LOG2+MAX_CODE) ticks.
- R8: A closed-interval code above MAX_CODE disables window mode, and the watchdog runs as in normal mode.
- R9: A write beat (`cfg_wr_valid`=1) updates `cfg_q` on the next edge only if `en` is 0 and the watchdog is idle. Otherwise the beat is dropped. `cfg_wr_ready` is always 1.
- R10: Once `rst_req` is 1 it stays 1, whatever `en`, `clr` and `tick` do, until `rst_n` is low.
- R11: Dropping `en` before a time-out returns the watchdog to idle. While it is idle, ticks and strobes have no effect. A later enable starts a full fresh period, and the window mode is sampled at that enable.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_boot | input | 8 | Nonvolatile setup value loaded during reset |
| en | input | 1 | Watchdog enable |
| win_mode | input | 1 | Window mode select, sampled at enable |
| tick | input | 1 | One-cycle pulse per oscillator period |
| clr | input | 1 | Restart strobe from software |
| cfg_wr_valid | input | 1 | Setup write beat valid |
| cfg_wr_data | input | 8 | Setup write beat data |
| cfg_wr_ready | output | 1 | Setup write ready, always 1 |
| cfg_q | output | 8 | Current setup word |
| rst_req | output | 1 | Registered sticky system-reset request |

## Verification
The bench builds the core with BASE_LOG2=1 and MAX_CODE=5. Legal lengths are then 2 to 64 ticks, and codes 6 to 15 are reserved. This makes an exhaustive sweep practical: every one of the sixteen time-out codes in normal mode, and every one of the sixteen closed-interval codes in window mode, each run to expiry. It also brings both reserved-code fallbacks within reach. Directed runs cover restarts at the first and last tick of each interval, restart against the final tick in the same cycle, disable and re-enable, and write protection.

// File: rtl/winwdog_pkg.sv
package winwdog_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_CLOSED = 2'd1,
    PH_OPEN   = 2'd2,
    PH_FIRED  = 2'd3
  } wd_phase_e;

  localparam int CODE_W = 4;
  localparam int CFG_W  = 2 * CODE_W;
endpackage

// File: rtl/winwdog_cfg_reg.sv
module winwdog_cfg_reg
  import winwdog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] boot_val,
  input  logic             lock,
  input  logic             wr_valid,
  input  logic [CFG_W-1:0] wr_data,
  output logic [CFG_W-1:0] word_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q <= boot_val;
    end else if (wr_valid && !lock) begin
      word_q <= wr_data;
    end
  end
endmodule

// File: rtl/winwdog_period_dec.sv
module winwdog_period_dec
  import winwdog_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int MAX_CODE  = 11,
  localparam int LEN_W    = BASE_LOG2 + MAX_CODE + 1
) (
  input  logic [CODE_W-1:0] code,
  output logic              legal,
  output logic [LEN_W-1:0]  len
);
  always_comb begin
    legal = (int'(code) <= MAX_CODE);
    if (legal) begin
      len = LEN_W'(1) << (BASE_LOG2 + int'(code));
    end else begin
      len = LEN_W'(1) << (BASE_LOG2 + MAX_CODE);
    end
  end
endmodule

// File: rtl/winwdog_seq.sv
module winwdog_seq
  import winwdog_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int MAX_CODE  = 11,
  localparam int LEN_W    = BASE_LOG2 + MAX_CODE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             win_mode,
  input  logic             win_legal,
  input  logic             tick,
  input  logic             clr,
  input  logic [LEN_W-1:0] closed_len,
  input  logic [LEN_W-1:0] open_len,
  output wd_phase_e        phase,
  output logic             fire_q
);
  wd_phase_e        ph_q, ph_d;
  logic [LEN_W-1:0] cnt_q, cnt_d;
  logic             win_q, win_d;
  logic             closed_last, open_last;

  assign closed_last = (cnt_q == closed_len - LEN_W'(1));
  assign open_last   = (cnt_q == open_len - LEN_W'(1));

  always_comb begin
    ph_d  = ph_q;
    cnt_d = cnt_q;
    win_d = win_q;
    unique case (ph_q)
      PH_IDLE: begin
        if (en) begin
          win_d = win_mode && win_legal;
          ph_d  = win_d ? PH_CLOSED : PH_OPEN;
          cnt_d = '0;
        end
      end
      PH_CLOSED: begin
        if (!en) begin
          ph_d = PH_IDLE;
        end else if (clr) begin
          ph_d = PH_FIRED;
        end else if (tick) begin
          if (closed_last) begin
            ph_d  = PH_OPEN;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
      end
      PH_OPEN: begin
        if (!en) begin
          ph_d = PH_IDLE;
        end else if (clr) begin
          ph_d  = win_q ? PH_CLOSED : PH_OPEN;
          cnt_d = '0;
        end else if (tick) begin
          if (open_last) begin
            ph_d = PH_FIRED;
          end else begin
            cnt_d = cnt_q + LEN_W'(1);
          end
        end
      end
      default: ph_d = PH_FIRED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      win_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      win_q  <= win_d;
      fire_q <= (ph_d == PH_FIRED);
    end
  end

  assign phase = ph_q;
endmodule

// File: rtl/winwdog_top.sv
module winwdog_top
  import winwdog_pkg::*;
#(
  parameter int BASE_LOG2 = 3,
  parameter int MAX_CODE  = 11,
  localparam int LEN_W    = BASE_LOG2 + MAX_CODE + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CFG_W-1:0] cfg_boot,
  input  logic             en,
  input  logic             win_mode,
  input  logic             tick,
  input  logic             clr,
  input  logic             cfg_wr_valid,
  input  logic [CFG_W-1:0] cfg_wr_data,
  output logic             cfg_wr_ready,
  output logic [CFG_W-1:0] cfg_q,
  output logic             rst_req
);
  wd_phase_e        phase;
  logic             lock;
  logic             win_legal, per_legal;
  logic [LEN_W-1:0] closed_len, open_len;

  assign lock         = en || (phase != PH_IDLE);
  assign cfg_wr_ready = 1'b1;

  winwdog_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .boot_val (cfg_boot),
    .lock     (lock),
    .wr_valid (cfg_wr_valid),
    .wr_data  (cfg_wr_data),
    .word_q   (cfg_q)
  );

  winwdog_period_dec #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_dec_closed (
    .code  (cfg_q[CFG_W-1:CODE_W]),
    .legal (win_legal),
    .len   (closed_len)
  );

  winwdog_period_dec #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_dec_open (
    .code  (cfg_q[CODE_W-1:0]),
    .legal (per_legal),
    .len   (open_len)
  );

  winwdog_seq #(.BASE_LOG2(BASE_LOG2), .MAX_CODE(MAX_CODE)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (en),
    .win_mode   (win_mode),
    .win_legal  (win_legal),
    .tick       (tick),
    .clr        (clr),
    .closed_len (closed_len),
    .open_len   (open_len),
    .phase      (phase),
    .fire_q     (rst_req)
  );

  logic unused_per_legal;
  assign unused_per_legal = per_legal;
endmodule

// File: rtl/winwdog_chk.sv
module winwdog_chk
  import winwdog_pkg::*;
#(
  parameter int MAX_CODE = 11
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             clr,
  input logic [CFG_W-1:0] cfg_q,
  input wd_phase_e        phase,
  input logic             rst_req
);
  // R10: the request never drops without a reset
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> rst_req);

  // R5: restart inside the closed interval fires at once
  p_early_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLOSED && en && clr) |=> rst_req);

  // R9: the setup word is frozen while enabled
  p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> $stable(cfg_q));

  // R11: an idle or disabled watchdog raises no request
  p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !rst_req) |=> !rst_req);

  // R8: a closed interval only exists with a legal closed code
  p_closed_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CLOSED) |-> (int'(cfg_q[CFG_W-1:CODE_W]) <= MAX_CODE));

  // R10: the request is high exactly in the fired phase
  p_req_phase_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req == (phase == PH_FIRED));
endmodule

bind winwdog_top winwdog_chk #(.MAX_CODE(MAX_CODE)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .en      (en),
  .clr     (clr),
  .cfg_q   (cfg_q),
  .phase   (phase),
  .rst_req (rst_req)
);

// File: tb/winwdog_top_tb.sv
module winwdog_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int BL = 1;
  localparam int MC = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] cfg_boot = 8'h00;
  logic       en = 1'b0, win_mode = 1'b0, tick = 1'b0, clr = 1'b0;
  logic       cfg_wr_valid = 1'b0;
  logic [7:0] cfg_wr_data = 8'h00;
  logic       cfg_wr_ready;
  logic [7:0] cfg_q;
  logic       rst_req;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  winwdog_top #(.BASE_LOG2(BL), .MAX_CODE(MC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_boot(cfg_boot), .en(en), .win_mode(win_mode),
    .tick(tick), .clr(clr), .cfg_wr_valid(cfg_wr_valid), .cfg_wr_data(cfg_wr_data),
    .cfg_wr_ready(cfg_wr_ready), .cfg_q(cfg_q), .rst_req(rst_req)
  );

  function automatic int len_of(input int code);
    return (code <= MC) ? (1 << (BL + code)) : (1 << (BL + MC));
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input logic [7:0] boot);
    rst_n = 1'b0; cfg_boot = boot; en = 1'b0; win_mode = 1'b0;
    tick = 1'b0; clr = 1'b0; cfg_wr_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic cyc(input logic t, input logic c);
    tick = t; clr = c;
    @(negedge clk);
    tick = 1'b0; clr = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1'b1, 1'b0);
  endtask

  task automatic wr(input logic [7:0] d);
    cfg_wr_valid = 1'b1; cfg_wr_data = d;
    @(negedge clk);
    cfg_wr_valid = 1'b0;
  endtask

  task automatic start(input logic wm);
    win_mode = wm; en = 1'b1;
    cyc(1'b1, 1'b0);
  endtask

  function automatic int run_to_fire();
    return 0;
  endfunction

  task automatic count_fire(output int n);
    n = 0;
    while (!rst_req && n < 400) begin
      cyc(1'b1, 1'b0);
      n++;
    end
  endtask

  initial begin : watchdog
    while (cycles < 150000) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=done", cycles);
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    int n;
    @(negedge clk);

    // R1 reset state and boot load
    do_reset(8'hA7);
    check("R1 cfg_q boot", cfg_q, 8'hA7);
    check("R1 rst_req after reset", rst_req, 0);
    check("R9 ready", cfg_wr_ready, 1);

    // R2 R3 R7 sweep of every time-out code in normal mode
    for (int p = 0; p < 16; p++) begin
      do_reset({4'h0, p[3:0]});
      start(1'b0);
      count_fire(n);
      check(p <= MC ? "R3 R2 normal expiry" : "R7 reserved time-out", n, len_of(p));
    end

    // R4 R8 sweep of every closed-interval code in window mode
    for (int w = 0; w < 16; w++) begin
      do_reset({w[3:0], 4'h1});
      start(1'b1);
      count_fire(n);
      check(w <= MC ? "R4 window expiry" : "R8 reserved closed code", n,
            (w <= MC ? len_of(w) : 0) + len_of(1));
    end

    // R5 restart at start and at last tick of closed interval (W=8, P=8)
    do_reset(8'h22); start(1'b1);
    cyc(1'b0, 1'b1);
    check("R5 clear at closed start", rst_req, 1);
    do_reset(8'h22); start(1'b1);
    ticks(7); check("R5 closed still quiet", rst_req, 0);
    cyc(1'b0, 1'b1);
    check("R5 clear at closed last tick", rst_req, 1);

    // R6 restart in open interval, then new closed interval
    do_reset(8'h22); start(1'b1);
    ticks(8); cyc(1'b0, 1'b1);
    check("R6 open clear accepted", rst_req, 0);
    ticks(7); cyc(1'b0, 1'b1);
    check("R6 new closed interval after restart", rst_req, 1);

    // R6 restart with final tick in normal mode (P=8)
    do_reset(8'h02); start(1'b0);
    ticks(7); cyc(1'b1, 1'b1);
    check("R6 restart beats final tick", rst_req, 0);
    ticks(7); check("R6 full new period", rst_req, 0);
    ticks(1); check("R6 expiry after restart", rst_req, 1);

    // R10 sticky request
    en = 1'b0; cyc(1'b1, 1'b1); ticks(3);
    check("R10 held after disable", rst_req, 1);
    wr(8'h11);
    check("R9 write dropped when fired", cfg_q, 8'h02);
    do_reset(8'h02);
    check("R10 cleared by reset", rst_req, 0);

    // R11 disable and re-enable
    start(1'b0); ticks(5);
    en = 1'b0; cyc(1'b0, 1'b0);
    ticks(20); cyc(1'b0, 1'b1);
    check("R11 idle ignores ticks", rst_req, 0);
    start(1'b0); ticks(7);
    check("R11 fresh period", rst_req, 0);
    ticks(1);
    check("R11 expiry after re-enable", rst_req, 1);

    // R9 write protection
    do_reset(8'h00);
    wr(8'h35);
    check("R9 write when idle", cfg_q, 8'h35);
    start(1'b0);
    wr(8'h12);
    check("R9 write dropped when enabled", cfg_q, 8'h35);
    en = 1'b0; cyc(1'b0, 1'b0);
    wr(8'h47);
    check("R9 write after disable", cfg_q, 8'h47);

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule